// File: doc/BRIEF.md
# Low-Depth Pixel TMDS Lane Encoder

This block turns one slot of video data into three 10-bit symbols for the three TMDS lanes of a DVI link. A slot is one of two things. It is either a pixel word, from which each lane pulls its own bit field, or a raw control word, which already holds three finished 10-bit symbols. A pixel word can be a packed low-depth pixel such as RGB332. For a pixel, each lane rotates the 32-bit data word, keeps a field of programmable width from the top of its low byte, and leaves the field there as an 8-bit channel value whose unused low bits are zero. The lane then encodes that value with the standard DVI transition-minimising stage and its DC-balancing stage. Each lane keeps its own running disparity.

Raw slots carry blanking periods. A timing generator outside the block builds them from the four control symbols. Lane 0 carries the syncs, with horizontal sync in control bit 0 and vertical sync in control bit 1. Both syncs are active low, so the idle level is code 11 and a sync pulse clears its bit. Lanes 1 and 2 always carry code 00. The three 30-bit results go to a serializer, which is outside this block. So is the timing generator.

Top module: `tmdsx_top`

## Requirements
- R1: When `slotValid` is high and `rawMode` is high, `symOut` equals `dataIn[29:0]` one clock later. No encoding is applied.
- R2: In both modes, lane n occupies `symOut[10n+9:10n]`. Lane 0 sits in the low bits. The control symbols are 0x354 for code 00, 0x0AB for code 01, 0x154 for code 10 and 0x2AB for code 11. Lane 0 control bit 0 is horizontal sync and control bit 1 is vertical sync.
- R3: In pixel mode, lane n forms its channel value from `dataIn`, using rotate amount r = `laneRot[5n+4:5n]` and width code w = `laneWidth[3n+2:3n]`. The steps are:
  1. Rotate `dataIn` right by r over all 32 bits.
  2. Take the low byte of the result.
  3. Keep only its top w+1 bits and clear the rest.
- R4: With the packed-pixel setting and pixel bits red = [1:0], green = [4:2], blue = [7:5], the channel values come out as follows:
  - Lane 0 (r=26, w=1) carries red in bits 7:6.
  - Lane 1 (r=29, w=2) carries green in bits 7:5.
  - Lane 2 (r=0, w=2) carries blue in bits 7:5.
- R5: The first stage of each lane works on the channel value D with the following rules:
  - Bit 8 of the symbol marks the stage used: 1 for XOR, 0 for XNOR.
  - XNOR is used when D has more than four ones, or exactly four ones with D[0]=0. Otherwise XOR is used.
  - As a check, the first pixel of value 0 after reset encodes to 0x100 on every lane.
- R6: Each lane keeps a signed running disparity. Bit 9 of the symbol chooses whether the 8 data bits are inverted, following the DVI balancing rules. After reset, two pixels of value 0 give 0x100 and then 0x3FF on every lane. The disparity stays even and never exceeds 8 in magnitude.
- R7: A raw slot sets the running disparity of all three lanes to zero.
- R8: While `slotValid` is low, `symOut` holds its value and no disparity changes.
- R9: During and after reset, `symValid` is 0, `symOut` is 0 and every disparity is 0.
- R10: `symValid` is high in exactly the cycle after each cycle in which `slotValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slotValid | input | 1 | One slot of data is present this cycle |
| rawMode | input | 1 | 1: raw control slot, 0: pixel slot |
| dataIn | input | 32 | Pixel word or raw symbol word |
| laneRot | input | 15 | Rotate-right amount, 5 bits per lane |
| laneWidth | input | 9 | Field width minus one, 3 bits per lane |
| symOut | output | 30 | Three lane symbols, lane 0 lowest |
| symValid | output | 1 | `symOut` holds a new result |

## Verification
Every result is due exactly one clock after the cycle its slot is presented, because a single register stage lies between the inputs and `symOut`/`symValid`. The driver presents a slot on a falling edge and queues the expected word, which comes from a separate model of the field extraction and DVI encoding. The monitor compares on the next falling edge, and it compares only when `symValid` is high. A valid with no queued item counts as a miscompare. Idle gaps are checked by sampling `symOut` before and after the gap, then continuing a pixel run whose expected symbols assume the disparity did not move during the gap.

// File: rtl/tmdsx_pkg.sv
package tmdsx_pkg;

  typedef struct packed {
    logic loadPix;
    logic loadRaw;
  } slotStrobeT;

  localparam logic [9:0] CTRL_SYM_00 = 10'h354;
  localparam logic [9:0] CTRL_SYM_01 = 10'h0AB;
  localparam logic [9:0] CTRL_SYM_10 = 10'h154;
  localparam logic [9:0] CTRL_SYM_11 = 10'h2AB;

endpackage

// File: rtl/tmdsx_ctrl.sv
module tmdsx_ctrl
  import tmdsx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       slotValid,
  input  logic       rawMode,
  output slotStrobeT strobe,
  output logic       symValid
);

  always_comb begin
    strobe.loadPix = slotValid && !rawMode;
    strobe.loadRaw = slotValid && rawMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) symValid <= 1'b0;
    else       symValid <= slotValid;
  end

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    slotValid |=> symValid);
  assert_no_spurious_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    !slotValid |=> !symValid);
  assert_strobe_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadPix, strobe.loadRaw}));

endmodule

// File: rtl/tmdsx_lane.sv
module tmdsx_lane
  import tmdsx_pkg::*;
#(
  parameter int CH_W   = 8,
  parameter int WORD_W = 32,
  parameter int DISP_W = 6,
  localparam int SYM_W = CH_W + 2,
  localparam int ROT_W = $clog2(WORD_W),
  localparam int NB_W  = $clog2(CH_W),
  localparam int CNT_W = $clog2(CH_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  slotStrobeT       strobe,
  input  logic [WORD_W-1:0] dataWord,
  input  logic [ROT_W-1:0] rotAmt,
  input  logic [NB_W-1:0]  widthCode,
  input  logic [SYM_W-1:0] rawSym,
  output logic [SYM_W-1:0] sym
);

  logic [2*WORD_W-1:0]        dblWord;
  logic [WORD_W-1:0]          rotWord;
  logic [NB_W:0]              fieldLen;
  logic [CH_W-1:0]            keepMask;
  logic [CH_W-1:0]            chanVal;
  logic [CNT_W-1:0]           onesIn;
  logic [CNT_W-1:0]           onesQm;
  logic                       useXnor;
  logic [CH_W:0]              qm;
  logic signed [DISP_W-1:0]   disp;
  logic signed [DISP_W-1:0]   dispNext;
  logic signed [DISP_W-1:0]   qmBias;
  logic [SYM_W-1:0]           encSym;

  // Field extraction: rotate right, keep the top bits of the low byte.
  always_comb begin
    dblWord  = {dataWord, dataWord} >> rotAmt;
    rotWord  = dblWord[WORD_W-1:0];
    fieldLen = {1'b0, widthCode} + 1'b1;
    keepMask = ~({CH_W{1'b1}} >> fieldLen);
    chanVal  = rotWord[CH_W-1:0] & keepMask;
  end

  // Transition-minimising stage.
  always_comb begin
    onesIn  = CNT_W'($countones(chanVal));
    useXnor = (onesIn > CNT_W'(CH_W / 2)) ||
              ((onesIn == CNT_W'(CH_W / 2)) && !chanVal[0]);
    qm      = '0;
    qm[0]   = chanVal[0];
    for (int i = 1; i < CH_W; i++) begin
      qm[i] = useXnor ? ~(qm[i-1] ^ chanVal[i]) : (qm[i-1] ^ chanVal[i]);
    end
    qm[CH_W] = !useXnor;
    onesQm   = CNT_W'($countones(qm[CH_W-1:0]));
  end

  // DC-balancing stage.
  always_comb begin
    qmBias = DISP_W'(2 * onesQm) - DISP_W'(CH_W);
    if (disp == '0 || qmBias == '0) begin
      encSym = {!qm[CH_W], qm[CH_W],
                qm[CH_W] ? qm[CH_W-1:0] : ~qm[CH_W-1:0]};
      dispNext = qm[CH_W] ? disp + qmBias : disp - qmBias;
    end else if ((disp > 0 && qmBias > 0) || (disp < 0 && qmBias < 0)) begin
      encSym   = {1'b1, qm[CH_W], ~qm[CH_W-1:0]};
      dispNext = disp + (qm[CH_W] ? DISP_W'(2) : DISP_W'(0)) - qmBias;
    end else begin
      encSym   = {1'b0, qm[CH_W], qm[CH_W-1:0]};
      dispNext = disp - (qm[CH_W] ? DISP_W'(0) : DISP_W'(2)) + qmBias;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sym  <= '0;
      disp <= '0;
    end else if (strobe.loadRaw) begin
      sym  <= rawSym;
      disp <= '0;
    end else if (strobe.loadPix) begin
      sym  <= encSym;
      disp <= dispNext;
    end
  end

  assert_disp_cleared_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadRaw |=> (disp == '0));
  assert_disp_even_R6: assert property (@(posedge clk) disable iff (!rstN)
    disp[0] == 1'b0);
  assert_disp_bounded_R6: assert property (@(posedge clk) disable iff (!rstN)
    (disp <= DISP_W'(CH_W)) && (disp >= -DISP_W'(CH_W)));
  assert_disp_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadPix || strobe.loadRaw) |=> $stable(disp));

endmodule

// File: rtl/tmdsx_datapath.sv
module tmdsx_datapath
  import tmdsx_pkg::*;
#(
  parameter int LANES  = 3,
  parameter int CH_W   = 8,
  parameter int WORD_W = 32,
  parameter int DISP_W = 6,
  localparam int SYM_W = CH_W + 2,
  localparam int ROT_W = $clog2(WORD_W),
  localparam int NB_W  = $clog2(CH_W)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  slotStrobeT               strobe,
  input  logic [WORD_W-1:0]        dataIn,
  input  logic [LANES*ROT_W-1:0]   laneRot,
  input  logic [LANES*NB_W-1:0]    laneWidth,
  output logic [LANES*SYM_W-1:0]   symOut
);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    tmdsx_lane #(
      .CH_W  (CH_W),
      .WORD_W(WORD_W),
      .DISP_W(DISP_W)
    ) uLane (
      .clk      (clk),
      .rstN     (rstN),
      .strobe   (strobe),
      .dataWord (dataIn),
      .rotAmt   (laneRot[g*ROT_W +: ROT_W]),
      .widthCode(laneWidth[g*NB_W +: NB_W]),
      .rawSym   (dataIn[g*SYM_W +: SYM_W]),
      .sym      (symOut[g*SYM_W +: SYM_W])
    );
  end

endmodule

// File: rtl/tmdsx_top.sv
module tmdsx_top
  import tmdsx_pkg::*;
#(
  parameter int LANES  = 3,
  parameter int CH_W   = 8,
  parameter int WORD_W = 32,
  parameter int DISP_W = 6,
  localparam int SYM_W = CH_W + 2,
  localparam int OUT_W = LANES * SYM_W,
  localparam int ROT_W = $clog2(WORD_W),
  localparam int NB_W  = $clog2(CH_W)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   slotValid,
  input  logic                   rawMode,
  input  logic [WORD_W-1:0]      dataIn,
  input  logic [LANES*ROT_W-1:0] laneRot,
  input  logic [LANES*NB_W-1:0]  laneWidth,
  output logic [OUT_W-1:0]       symOut,
  output logic                   symValid
);

  slotStrobeT strobe;

  tmdsx_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .slotValid(slotValid),
    .rawMode  (rawMode),
    .strobe   (strobe),
    .symValid (symValid)
  );

  tmdsx_datapath #(
    .LANES (LANES),
    .CH_W  (CH_W),
    .WORD_W(WORD_W),
    .DISP_W(DISP_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dataIn   (dataIn),
    .laneRot  (laneRot),
    .laneWidth(laneWidth),
    .symOut   (symOut)
  );

  assert_raw_passthrough_R1: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid && rawMode) |=> (symOut == $past(dataIn[OUT_W-1:0])));
  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !slotValid |=> $stable(symOut));

endmodule

// File: tb/tmdsx_top_test.sv
module tmdsx_top_test;
  import tmdsx_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slotValid = 1'b0;
  logic        rawMode = 1'b0;
  logic [31:0] dataIn = '0;
  logic [14:0] laneRot = '0;
  logic [8:0]  laneWidth = '0;
  logic [29:0] symOut;
  logic        symValid;

  int vectors = 0;
  int misses = 0;
  int modelDisp [3];
  logic [29:0] expQ [$];
  string       tagQ [$];
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmdsx_top uut (
    .clk(clk), .rstN(rstN), .slotValid(slotValid), .rawMode(rawMode),
    .dataIn(dataIn), .laneRot(laneRot), .laneWidth(laneWidth),
    .symOut(symOut), .symValid(symValid)
  );

  task automatic check(input logic [29:0] act, input logic [29:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Independent reference of the extraction and DVI encoding.
  function automatic logic [7:0] refChan(input logic [31:0] w, input int r, input int wc);
    logic [31:0] rw;
    logic [7:0]  ch;
    rw = (w >> r) | ((r == 0) ? 32'h0 : (w << (32 - r)));
    ch = '0;
    for (int b = 0; b < 8; b++) if (b >= 7 - wc) ch[b] = rw[b];
    return ch;
  endfunction

  task automatic refEnc(input int ln, input logic [7:0] d, output logic [9:0] q);
    logic [8:0] m;
    int ones, n1, n0;
    ones = 0;
    for (int b = 0; b < 8; b++) ones += d[b];
    m[0] = d[0];
    if (ones > 4 || (ones == 4 && d[0] == 1'b0)) begin
      for (int b = 1; b < 8; b++) m[b] = m[b-1] ~^ d[b];
      m[8] = 1'b0;
    end else begin
      for (int b = 1; b < 8; b++) m[b] = m[b-1] ^ d[b];
      m[8] = 1'b1;
    end
    n1 = 0;
    for (int b = 0; b < 8; b++) n1 += m[b];
    n0 = 8 - n1;
    if (modelDisp[ln] == 0 || n1 == n0) begin
      q = {~m[8], m[8], m[8] ? m[7:0] : ~m[7:0]};
      modelDisp[ln] += m[8] ? (n1 - n0) : (n0 - n1);
    end else if ((modelDisp[ln] > 0 && n1 > n0) || (modelDisp[ln] < 0 && n0 > n1)) begin
      q = {1'b1, m[8], ~m[7:0]};
      modelDisp[ln] += 2 * int'(m[8]) + n0 - n1;
    end else begin
      q = {1'b0, m[8], m[7:0]};
      modelDisp[ln] += -2 * int'(!m[8]) + n1 - n0;
    end
  endtask

  task automatic setCfg(input int r0, w0, r1, w1, r2, w2);
    laneRot   = {5'(r2), 5'(r1), 5'(r0)};
    laneWidth = {3'(w2), 3'(w1), 3'(w0)};
  endtask

  task automatic modelPixel(input logic [31:0] w, output logic [29:0] e);
    logic [9:0] s;
    for (int ln = 0; ln < 3; ln++) begin
      refEnc(ln, refChan(w, int'(laneRot[5*ln +: 5]), int'(laneWidth[3*ln +: 3])), s);
      e[10*ln +: 10] = s;
    end
  endtask

  // Drivers: called at a falling edge, return at the next falling edge.
  task automatic sendPixel(input logic [31:0] w, input string tag);
    logic [29:0] e;
    slotValid = 1'b1; rawMode = 1'b0; dataIn = w;
    modelPixel(w, e);
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    slotValid = 1'b0;
  endtask

  task automatic sendPixelKnown(input logic [31:0] w, input logic [29:0] lit, input string tag);
    logic [29:0] e;
    slotValid = 1'b1; rawMode = 1'b0; dataIn = w;
    modelPixel(w, e);
    expQ.push_back(lit); tagQ.push_back(tag);
    @(negedge clk);
    slotValid = 1'b0;
  endtask

  task automatic sendRaw(input logic [29:0] w, input string tag);
    slotValid = 1'b1; rawMode = 1'b1; dataIn = {2'b00, w};
    for (int ln = 0; ln < 3; ln++) modelDisp[ln] = 0;
    expQ.push_back(w); tagQ.push_back(tag);
    @(negedge clk);
    slotValid = 1'b0;
  endtask

  function automatic logic [29:0] blankWord(input logic vs, input logic hs);
    logic [9:0] l0;
    case ({vs, hs})
      2'b00: l0 = CTRL_SYM_00;
      2'b01: l0 = CTRL_SYM_01;
      2'b10: l0 = CTRL_SYM_10;
      default: l0 = CTRL_SYM_11;
    endcase
    return {CTRL_SYM_00, CTRL_SYM_00, l0};
  endfunction

  // Monitor: scoreboard pop and compare.
  always @(negedge clk) begin
    if (rstN && symValid) begin
      if (expQ.size() == 0) begin
        vectors++; misses++;
        $display("FAIL R10: valid with nothing expected, got %h expected none", symOut);
      end else begin
        check(symOut, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [29:0] held;
    for (int ln = 0; ln < 3; ln++) modelDisp[ln] = 0;
    repeat (3) @(negedge clk);
    check(symOut, 30'h0, "R9 reset output");
    check({29'h0, symValid}, 30'h0, "R9 reset valid");
    rstN = 1'b1;
    @(negedge clk);

    // RGB332 setting (R4)
    setCfg(26, 1, 29, 2, 0, 2);
    sendPixelKnown(32'h00, 30'h10040100, "R5 first zero pixel");
    sendPixelKnown(32'h00, 30'h3FFFFFFF, "R6 second zero pixel");
    sendPixel(32'hFF, "R4 white pixel");
    sendPixel(32'h03, "R4 red only");
    sendPixel(32'h1C, "R4 green only");
    sendPixel(32'hE0, "R4 blue only");

    // Raw blanking words (R1, R2) and disparity reset (R7)
    sendRaw(blankWord(1'b1, 1'b1), "R2 idle blank");
    sendRaw(blankWord(1'b1, 1'b0), "R2 hsync pulse");
    sendRaw(blankWord(1'b0, 1'b1), "R2 vsync pulse");
    sendRaw(blankWord(1'b0, 1'b0), "R2 both pulses");
    sendRaw(30'h2A5_5A5A5 & 30'h3FFFFFFF, "R1 arbitrary raw");
    sendPixelKnown(32'h00, 30'h10040100, "R7 disparity cleared by raw");

    // Other field settings (R3)
    setCfg(8, 7, 4, 0, 28, 3);
    sendPixel(32'h1234A5F0, "R3 full byte rot8");
    sendPixel(32'hFFFF00F0, "R3 single bit and nibble");
    setCfg(31, 7, 16, 5, 24, 7);
    sendPixel(32'h80C3_3C01, "R3 wrap rotate");

    // Idle gap: output holds (R8), valid low (R10)
    @(negedge clk);
    held = symOut;
    repeat (5) @(negedge clk);
    check(symOut, held, "R8 hold during gap");
    check({29'h0, symValid}, 30'h0, "R10 no valid when idle");
    sendPixel(32'h5A5A5A5A, "R8 disparity kept over gap");

    // Mixed run (R5, R6)
    setCfg(26, 1, 29, 2, 0, 2);
    for (int i = 0; i < 200; i++) begin
      if (i % 37 == 36) sendRaw(blankWord(i[0], i[1]), "R7 raw in run");
      else sendPixel($urandom, "R6 pixel run");
      if (i % 23 == 22) repeat (2) @(negedge clk);
    end

    repeat (3) @(negedge clk);
    vectors++;
    if (expQ.size() != 0) begin
      misses++;
      $display("FAIL R10: %0d results missing, got %0d expected 0", expQ.size(), expQ.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule